// File: doc/BRIEF.md
# Shared-Pin Boundary-Scan and Programming Port

This block is the serial test front end of a chip. Four serial pins (clock, mode, data in, data out) are owned either by a standard boundary-scan TAP controller or by a small programming state machine. A mode-select input chooses the owner: high gives the pins to the TAP, low gives them to the programming engine. When mode-select goes from high to low, the block enters programming mode and turns off every user pad driver.

On the TAP side there is the usual sixteen-state controller, an instruction register, a one-bit bypass register and a boundary chain. The chain isolates a set of bidirectional pads and a set of input-only pads. Each bidirectional pad has three chain cells: the value seen at the pad, the value driven, and the drive enable. Each input-only pad has one cell. The supported instructions are BYPASS, SAMPLE and EXTEST.

All serial pins are sampled in the system clock domain. Serial clock edges are detected there, so the serial clock has to run well below the system clock. The programming engine collects a command word bit by bit and raises a one-cycle strobe when it reaches its execute phase.

Top module: `dual_test_port`

## Requirements
- R1: With scan_sel high, the serial pins drive only the TAP and the programming phase does not move. With scan_sel low, the TAP state does not move, ser_dout carries bit 0 of prog_word, and ser_dout_en is 1.
- R2: A high-to-low change of scan_sel sets prog_active and forces every pad_oe bit to 0. A low-to-high change clears prog_active, and pad_oe again follows its normal source.
- R3: Driving trst_n low puts the TAP in Test-Logic-Reset (tap_state 0) at once, without waiting for a clock edge. It also clears ser_dout_en and selects BYPASS. The synchronous rst does the same.
- R4: The TAP follows the standard sixteen-state graph on each serial clock rise. Five rises with the mode pin high reach Test-Logic-Reset from any state. tap_state codes: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2..8 the DR column from select to update, 9..15 the IR column likewise, so Shift-DR is 4 and Shift-IR is 11.
- R5: The data-in pin is taken on a serial clock rise. ser_dout and ser_dout_en change only after a serial clock fall. In scan mode, ser_dout_en is 1 only after a fall in Shift-DR or Shift-IR.
- R6: Capture-IR loads 4'b0001, and it is shifted out least significant bit first. The 4-bit instruction codes are EXTEST 0000, SAMPLE 0010 and BYPASS 1111.
- R7: Under BYPASS, and under any code that is not defined, the data register is one bit that captures 0. The pads follow core_out and core_oe.
- R8: SAMPLE captures the chain without touching the pads. For pad i, bit 3i holds pad_in[i], bit 3i+1 holds core_out[i] and bit 3i+2 holds core_oe[i]. Input-only pad j is at bit 3*NB+j. Bit 0 leaves first.
- R9: While EXTEST is the current instruction, the update cells drive the pins. pad_out[i] comes from bit 3i+1, pad_oe[i] from bit 3i+2, core_in[i] from bit 3i, and inpin_core[j] from bit 3*NB+j. The update cells load on the serial clock rise that leaves Update-DR.
- R10: In programming mode, a serial clock rise with the mode pin high steps the phase idle(0) to shift(1), shift to execute(2), and execute back to idle. Entering execute gives exactly one prog_go pulse.
- R11: In the shift phase, a rise with the mode pin low moves the data-in bit into prog_word[PW-1] and shifts the word right by one, so the first bit sent ends in bit 0. In the idle and execute phases, mode-low rises leave prog_word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| scan_sel | input | 1 | Pin owner select: 1 TAP, 0 programming engine |
| ser_clk | input | 1 | Shared serial clock pin |
| ser_mode | input | 1 | Shared mode pin (TMS or programming mode) |
| ser_din | input | 1 | Shared serial data in |
| ser_dout | output | 1 | Shared serial data out |
| ser_dout_en | output | 1 | Drive enable for ser_dout |
| prog_active | output | 1 | Programming mode held, pads off |
| tap_state | output | 4 | Current TAP controller state code |
| prog_phase | output | 2 | Programming engine phase |
| prog_word | output | PW | Programming shift word |
| prog_go | output | 1 | One-cycle strobe on entering execute |
| core_out | input | NB | Core value for each bidirectional pad |
| core_oe | input | NB | Core drive enable for each bidirectional pad |
| core_in | output | NB | Pad value presented to the core |
| pad_in | input | NB | Value at each bidirectional pad |
| pad_out | output | NB | Value driven to each bidirectional pad |
| pad_oe | output | NB | Drive enable of each bidirectional pad |
| inpin_pad | input | NI | Value at each input-only pad |
| inpin_core | output | NI | Input-only pad value presented to the core |

## Verification
The assertions assume that trst_n and scan_sel change only away from the system clock edge. They also assume that each serial clock level lasts several system clock cycles, so that every rise is followed by a detected fall before the next rise. The bench keeps to this: every serial level lasts six system cycles, and the mode and data pins are set three cycles before the rising clock. Random mode-pin walks run through the TAP graph and are checked against a model. The directed cases cover the instruction capture pattern, undefined codes, preload-then-EXTEST, asynchronous TRST in the middle of a shift, and mode-low edges in the non-shift programming phases.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = '0;
    localparam opcode_t OP_SAMPLE  = opcode_t'(2);
    localparam opcode_t OP_BYPASS  = '1;
    localparam opcode_t IR_CAPTURE = opcode_t'(1);

    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_DR_SEL   = 4'd2,
        TS_DR_CAP   = 4'd3,
        TS_DR_SHIFT = 4'd4,
        TS_DR_EXIT1 = 4'd5,
        TS_DR_PAUSE = 4'd6,
        TS_DR_EXIT2 = 4'd7,
        TS_DR_UPD   = 4'd8,
        TS_IR_SEL   = 4'd9,
        TS_IR_CAP   = 4'd10,
        TS_IR_SHIFT = 4'd11,
        TS_IR_EXIT1 = 4'd12,
        TS_IR_PAUSE = 4'd13,
        TS_IR_EXIT2 = 4'd14,
        TS_IR_UPD   = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_EXEC  = 2'd2
    } prog_phase_e;

    typedef enum logic {
        DR_BYPASS   = 1'b0,
        DR_BOUNDARY = 1'b1
    } dr_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic mode;
        logic din;
    } ser_evt_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   n = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   n = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: n = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: n = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: n = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: n = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   n = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   n = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   n = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: n = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: n = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: n = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: n = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   n = tms ? TS_DR_SEL   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e decode_dr(input opcode_t op);
        return (op == OP_EXTEST || op == OP_SAMPLE) ? DR_BOUNDARY : DR_BYPASS;
    endfunction

endpackage

// File: rtl/tp_pin_sync.sv
module tp_pin_sync
    import tp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_pin,
    input  logic     clk_pin,
    input  logic     mode_pin,
    input  logic     din_pin,
    output logic     scan_q,
    output logic     prog_hold,
    output ser_evt_t evt
);
    localparam int          NPIN    = 4;
    localparam logic [3:0]  RST_VAL = 4'b1000;

    logic [NPIN-1:0] meta;
    logic [NPIN-1:0] stab;
    logic            sclk_d;
    logic            sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta      <= RST_VAL;
            stab      <= RST_VAL;
            sclk_d    <= 1'b0;
            sel_d     <= 1'b1;
            prog_hold <= 1'b0;
        end else begin
            meta   <= {sel_pin, clk_pin, mode_pin, din_pin};
            stab   <= meta;
            sclk_d <= stab[2];
            sel_d  <= stab[3];
            if (sel_d && !stab[3]) begin
                prog_hold <= 1'b1;
            end else if (!sel_d && stab[3]) begin
                prog_hold <= 1'b0;
            end
        end
    end

    assign scan_q   = stab[3];
    assign evt.rise = stab[2] & ~sclk_d;
    assign evt.fall = ~stab[2] & sclk_d;
    assign evt.mode = stab[1];
    assign evt.din  = stab[0];

endmodule

// File: rtl/tp_tap_fsm.sv
module tp_tap_fsm
    import tp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trst_n,
    input  logic       step,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            state <= TS_RESET;
        end else if (rst) begin
            state <= TS_RESET;
        end else if (step) begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/tp_tap_regs.sv
module tp_tap_regs
    import tp_pkg::*;
#(
    parameter int NB = 4,
    parameter int NI = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                tdi,
    input  tap_state_e          state,
    input  logic [NB-1:0]       core_out,
    input  logic [NB-1:0]       core_oe,
    input  logic [NB-1:0]       pad_in,
    input  logic [NI-1:0]       inpin_pad,
    output logic [3*NB+NI-1:0]  upd_cells,
    output logic                extest,
    output logic                tdo,
    output logic                tdo_oe
);
    localparam int CH = 3 * NB + NI;

    opcode_t       ir;
    opcode_t       ir_sr;
    logic          byp;
    logic [CH-1:0] bsr;
    logic [CH-1:0] cap_vec;
    dr_sel_e       dsel;

    assign dsel   = decode_dr(ir);
    assign extest = (ir == OP_EXTEST);

    for (genvar g = 0; g < NB; g++) begin : g_bidir
        assign cap_vec[3*g]     = pad_in[g];
        assign cap_vec[3*g + 1] = core_out[g];
        assign cap_vec[3*g + 2] = core_oe[g];
    end
    for (genvar g = 0; g < NI; g++) begin : g_inonly
        assign cap_vec[3*NB + g] = inpin_pad[g];
    end

    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            ir        <= OP_BYPASS;
            ir_sr     <= '0;
            byp       <= 1'b0;
            bsr       <= '0;
            upd_cells <= '0;
            tdo       <= 1'b0;
            tdo_oe    <= 1'b0;
        end else if (rst) begin
            ir        <= OP_BYPASS;
            ir_sr     <= '0;
            byp       <= 1'b0;
            bsr       <= '0;
            upd_cells <= '0;
            tdo       <= 1'b0;
            tdo_oe    <= 1'b0;
        end else begin
            if (rise) begin
                case (state)
                    TS_RESET:    ir    <= OP_BYPASS;
                    TS_IR_CAP:   ir_sr <= IR_CAPTURE;
                    TS_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                    TS_IR_UPD:   ir    <= ir_sr;
                    TS_DR_CAP: begin
                        if (dsel == DR_BOUNDARY) bsr <= cap_vec;
                        else                     byp <= 1'b0;
                    end
                    TS_DR_SHIFT: begin
                        if (dsel == DR_BOUNDARY) bsr <= {tdi, bsr[CH-1:1]};
                        else                     byp <= tdi;
                    end
                    TS_DR_UPD: begin
                        if (dsel == DR_BOUNDARY) upd_cells <= bsr;
                    end
                    default: ;
                endcase
            end
            if (fall) begin
                tdo_oe <= (state == TS_DR_SHIFT) || (state == TS_IR_SHIFT);
                if (state == TS_IR_SHIFT)       tdo <= ir_sr[0];
                else if (dsel == DR_BOUNDARY)   tdo <= bsr[0];
                else                            tdo <= byp;
            end
        end
    end

endmodule

// File: rtl/tp_prog_sm.sv
module tp_prog_sm
    import tp_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          mode,
    input  logic          din,
    output prog_phase_e   phase,
    output logic [PW-1:0] word,
    output logic          go
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            word  <= '0;
            go    <= 1'b0;
        end else begin
            go <= 1'b0;
            if (step) begin
                if (mode) begin
                    case (phase)
                        PH_IDLE:  phase <= PH_SHIFT;
                        PH_SHIFT: begin
                            phase <= PH_EXEC;
                            go    <= 1'b1;
                        end
                        default:  phase <= PH_IDLE;
                    endcase
                end else if (phase == PH_SHIFT) begin
                    word <= {din, word[PW-1:1]};
                end
            end
        end
    end

endmodule

// File: rtl/dual_test_port.sv
module dual_test_port
    import tp_pkg::*;
#(
    parameter int NB = 4,
    parameter int NI = 2,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trst_n,
    input  logic          scan_sel,
    input  logic          ser_clk,
    input  logic          ser_mode,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_dout_en,
    output logic          prog_active,
    output logic [3:0]    tap_state,
    output logic [1:0]    prog_phase,
    output logic [PW-1:0] prog_word,
    output logic          prog_go,
    input  logic [NB-1:0] core_out,
    input  logic [NB-1:0] core_oe,
    output logic [NB-1:0] core_in,
    input  logic [NB-1:0] pad_in,
    output logic [NB-1:0] pad_out,
    output logic [NB-1:0] pad_oe,
    input  logic [NI-1:0] inpin_pad,
    output logic [NI-1:0] inpin_core
);
    localparam int CH = 3 * NB + NI;

    ser_evt_t      evt;
    logic          scan_q;
    logic          tck_rise;
    logic          tck_fall;
    logic          sck_rise;
    tap_state_e    st;
    prog_phase_e   ph;
    logic [CH-1:0] upd;
    logic          extest;
    logic          tdo;
    logic          tdo_oe;

    tp_pin_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .sel_pin   (scan_sel),
        .clk_pin   (ser_clk),
        .mode_pin  (ser_mode),
        .din_pin   (ser_din),
        .scan_q    (scan_q),
        .prog_hold (prog_active),
        .evt       (evt)
    );

    assign tck_rise = evt.rise & scan_q;
    assign tck_fall = evt.fall & scan_q;
    assign sck_rise = evt.rise & ~scan_q;

    tp_tap_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .trst_n (trst_n),
        .step   (tck_rise),
        .tms    (evt.mode),
        .state  (st)
    );

    tp_tap_regs #(.NB(NB), .NI(NI)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .trst_n    (trst_n),
        .rise      (tck_rise),
        .fall      (tck_fall),
        .tdi       (evt.din),
        .state     (st),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_in    (pad_in),
        .inpin_pad (inpin_pad),
        .upd_cells (upd),
        .extest    (extest),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe)
    );

    tp_prog_sm #(.PW(PW)) u_prog (
        .clk   (clk),
        .rst   (rst),
        .step  (sck_rise),
        .mode  (evt.mode),
        .din   (evt.din),
        .phase (ph),
        .word  (prog_word),
        .go    (prog_go)
    );

    assign tap_state   = st;
    assign prog_phase  = ph;
    assign ser_dout    = scan_q ? tdo    : prog_word[0];
    assign ser_dout_en = scan_q ? tdo_oe : 1'b1;

    for (genvar i = 0; i < NB; i++) begin : g_pad
        assign pad_out[i] = extest ? upd[3*i + 1] : core_out[i];
        assign pad_oe[i]  = prog_active ? 1'b0 : (extest ? upd[3*i + 2] : core_oe[i]);
        assign core_in[i] = extest ? upd[3*i] : pad_in[i];
    end
    for (genvar j = 0; j < NI; j++) begin : g_inpin
        assign inpin_core[j] = extest ? upd[3*NB + j] : inpin_pad[j];
    end

endmodule

// File: rtl/tp_checker.sv
module tp_checker (
    input logic       clk,
    input logic       rst,
    input logic       trst_n,
    input logic       scan_q,
    input logic       tck_rise,
    input logic [3:0] tap_state,
    input logic       ser_dout_en,
    input logic       prog_active,
    input logic       pad_oe_any,
    input logic       prog_go,
    input logic [1:0] prog_phase
);
    AST_PADS_OFF_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        prog_active |-> !pad_oe_any); // R2

    AST_TRST_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
        !trst_n |-> tap_state == 4'd0); // R3

    AST_TAP_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (rst || !trst_n)
        !tck_rise |=> $stable(tap_state)); // R1

    AST_TDO_EN_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (scan_q && ser_dout_en) |-> (tap_state == 4'd4 || tap_state == 4'd5 ||
                                     tap_state == 4'd11 || tap_state == 4'd12)); // R5

    AST_GO_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> prog_phase == 2'd2); // R10

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go); // R10

endmodule

bind dual_test_port tp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .trst_n      (trst_n),
    .scan_q      (scan_q),
    .tck_rise    (tck_rise),
    .tap_state   (tap_state),
    .ser_dout_en (ser_dout_en),
    .prog_active (prog_active),
    .pad_oe_any  (|pad_oe),
    .prog_go     (prog_go),
    .prog_phase  (prog_phase)
);

// File: tb/dual_test_port_bench.sv
module dual_test_port_bench;
    localparam int NB = 4;
    localparam int NI = 2;
    localparam int PW = 8;
    localparam int CH = 3 * NB + NI;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, trst_n, scan_sel, ser_clk, ser_mode, ser_din;
    logic          ser_dout, ser_dout_en, prog_active, prog_go;
    logic [3:0]    tap_state;
    logic [1:0]    prog_phase;
    logic [PW-1:0] prog_word;
    logic [NB-1:0] core_out, core_oe, core_in, pad_in, pad_out, pad_oe;
    logic [NI-1:0] inpin_pad, inpin_core;

    dual_test_port #(.NB(NB), .NI(NI), .PW(PW)) u_dual_test_port (
        .clk(clk), .rst(rst), .trst_n(trst_n), .scan_sel(scan_sel),
        .ser_clk(ser_clk), .ser_mode(ser_mode), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .prog_active(prog_active),
        .tap_state(tap_state), .prog_phase(prog_phase), .prog_word(prog_word),
        .prog_go(prog_go), .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .inpin_pad(inpin_pad), .inpin_core(inpin_core)
    );

    int errors = 0;
    int checks = 0;
    int go_cnt = 0;
    int mst    = 0;
    bit done   = 1'b0;

    always @(negedge clk) if (prog_go) go_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_next(input int s, input bit t);
        case (s)
            0:  return t ? 0 : 1;
            1:  return t ? 2 : 1;
            2:  return t ? 9 : 3;
            3:  return t ? 5 : 4;
            4:  return t ? 5 : 4;
            5:  return t ? 8 : 6;
            6:  return t ? 7 : 6;
            7:  return t ? 8 : 4;
            8:  return t ? 2 : 1;
            9:  return t ? 0 : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    function automatic logic [63:0] exp_cap();
        logic [63:0] v = '0;
        for (int i = 0; i < NB; i++) begin
            v[3*i]     = pad_in[i];
            v[3*i + 1] = core_out[i];
            v[3*i + 2] = core_oe[i];
        end
        for (int j = 0; j < NI; j++) v[3*NB + j] = inpin_pad[j];
        return v;
    endfunction

    task automatic pulse(input bit m, input bit d, output bit so, output bit se);
        ser_mode = m;
        ser_din  = d;
        idle(3);
        so = ser_dout;
        se = ser_dout_en;
        ser_clk = 1'b1;
        idle(6);
        ser_clk = 1'b0;
        idle(6);
        if (scan_sel) mst = model_next(mst, m);
    endtask

    task automatic step(input bit m, input bit d);
        bit a, b;
        pulse(m, d, a, b);
    endtask

    task automatic scan_reg(input bit is_ir, input logic [63:0] din, input int n,
                            output logic [63:0] dout, output bit en_all);
        bit b, e;
        dout   = '0;
        en_all = 1'b1;
        step(1, 0);
        if (is_ir) step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int k = 0; k < n; k++) begin
            pulse(k == n - 1, din[k], b, e);
            dout[k] = b;
            en_all  = en_all & e;
        end
        step(1, 0);
        step(0, 0);
    endtask

    task automatic randomize_pins();
        core_out  = NB'($urandom);
        core_oe   = NB'($urandom);
        pad_in    = NB'($urandom);
        inpin_pad = NI'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, q, e;
        bit          en, so, se;
        int          tsave, gc0;

        void'($urandom(32'd20240611));
        rst = 1'b1; trst_n = 1'b1; scan_sel = 1'b1;
        ser_clk = 1'b0; ser_mode = 1'b0; ser_din = 1'b0;
        randomize_pins();
        idle(5);
        rst = 1'b0;
        idle(4);

        chk("R3 reset state", 64'(tap_state), 64'd0);
        chk("R5 dout disabled after reset", 64'(ser_dout_en), 64'd0);
        chk("R2 prog inactive after reset", 64'(prog_active), 64'd0);
        chk("R10 phase idle after reset", 64'(prog_phase), 64'd0);
        chk("R7 pads follow core after reset", 64'(pad_out), 64'(core_out));

        // R4/R5: random walks against a model of the graph
        for (int r = 0; r < 10; r++) begin
            int len = $urandom_range(3, 14);
            for (int k = 0; k < len; k++) begin
                step(1'($urandom), 1'($urandom));
                chk("R4 tap state walk", 64'(tap_state), 64'(mst));
                chk("R5 dout enable in shift", 64'(ser_dout_en),
                    64'((mst == 4 || mst == 11) ? 1 : 0));
            end
            for (int k = 0; k < 5; k++) step(1, 0);
            chk("R4 five ones reach reset", 64'(tap_state), 64'd0);
        end
        step(0, 0);
        chk("R4 run-test idle", 64'(tap_state), 64'd1);

        // R6: instruction capture pattern
        scan_reg(1, 64'hF, 4, q, en);
        chk("R6 ir capture", q & 64'hF, 64'h1);
        chk("R5 dout enabled through ir shift", 64'(en), 64'd1);

        // R7: bypass and undefined codes
        d = 64'($urandom);
        scan_reg(0, d, 8, q, en);
        chk("R7 bypass delay", q & 64'hFF, {d[62:0], 1'b0} & 64'hFF);
        scan_reg(1, 64'h5, 4, q, en);
        d = 64'($urandom);
        scan_reg(0, d, 8, q, en);
        chk("R7 undefined code acts as bypass", q & 64'hFF, {d[62:0], 1'b0} & 64'hFF);
        chk("R7 pads follow core", 64'(pad_out), 64'(core_out));

        // R8: sample several random pin patterns
        scan_reg(1, 64'h2, 4, q, en);
        for (int r = 0; r < 4; r++) begin
            randomize_pins();
            idle(2);
            e = exp_cap();
            d = 64'($urandom) & ((64'd1 << CH) - 1);
            scan_reg(0, d, CH, q, en);
            chk("R8 sample capture", q & ((64'd1 << CH) - 1), e);
            chk("R8 sample leaves pad_out", 64'(pad_out), 64'(core_out));
            chk("R8 sample leaves pad_oe", 64'(pad_oe), 64'(core_oe));
            chk("R8 sample leaves core_in", 64'(core_in), 64'(pad_in));
        end

        // R9: EXTEST drives from cells preloaded by the last SAMPLE scan
        scan_reg(1, 64'h0, 4, q, en);
        for (int i = 0; i < NB; i++) begin
            chk("R9 preload pad_out", 64'(pad_out[i]), 64'(d[3*i + 1]));
            chk("R9 preload pad_oe", 64'(pad_oe[i]), 64'(d[3*i + 2]));
            chk("R9 preload core_in", 64'(core_in[i]), 64'(d[3*i]));
        end
        chk("R9 preload inpin_core", 64'(inpin_core), (d >> (3*NB)) & ((64'd1 << NI) - 1));
        randomize_pins();
        idle(2);
        e = exp_cap();
        d = 64'($urandom) & ((64'd1 << CH) - 1);
        scan_reg(0, d, CH, q, en);
        chk("R9 extest capture", q & ((64'd1 << CH) - 1), e);
        for (int i = 0; i < NB; i++) begin
            chk("R9 extest pad_out", 64'(pad_out[i]), 64'(d[3*i + 1]));
            chk("R9 extest pad_oe", 64'(pad_oe[i]), 64'(d[3*i + 2]));
        end

        // R3: asynchronous TRST in the middle of Shift-DR
        step(1, 0); step(0, 0); step(0, 0);
        chk("R4 reached shift-dr", 64'(tap_state), 64'd4);
        trst_n = 1'b0;
        #2;
        chk("R3 trst immediate reset", 64'(tap_state), 64'd0);
        chk("R3 trst clears dout enable", 64'(ser_dout_en), 64'd0);
        chk("R3 trst selects bypass", 64'(pad_out), 64'(core_out));
        mst = 0;
        idle(2);
        trst_n = 1'b1;
        idle(2);
        step(0, 0);
        chk("R3 leaves reset after trst", 64'(tap_state), 64'd1);

        // R1/R2/R10/R11: programming mode
        chk("R1 phase unmoved in scan mode", 64'(prog_phase), 64'd0);
        tsave = int'(tap_state);
        scan_sel = 1'b0;
        idle(6);
        chk("R2 prog active after fall", 64'(prog_active), 64'd1);
        chk("R2 pads off", 64'(pad_oe), 64'd0);
        chk("R1 sdo enabled", 64'(ser_dout_en), 64'd1);
        for (int k = 0; k < 3; k++) step(0, 1);
        chk("R11 idle ignores data", 64'(prog_word), 64'd0);
        step(1, 0);
        chk("R10 idle to shift", 64'(prog_phase), 64'd1);
        d = 64'($urandom) & ((64'd1 << PW) - 1);
        for (int k = 0; k < PW; k++) step(0, d[k]);
        chk("R11 word assembled", 64'(prog_word), d);
        chk("R1 sdo carries word lsb", 64'(ser_dout), 64'(d[0]));
        gc0 = go_cnt;
        step(1, 0);
        chk("R10 shift to exec", 64'(prog_phase), 64'd2);
        chk("R10 single go pulse", 64'(go_cnt), 64'(gc0 + 1));
        step(0, ~d[0]);
        chk("R11 exec ignores data", 64'(prog_word), d);
        step(1, 0);
        chk("R10 exec to idle", 64'(prog_phase), 64'd0);
        chk("R1 tap frozen in prog mode", 64'(tap_state), 64'(tsave));
        pulse(0, 0, so, se);
        scan_sel = 1'b1;
        idle(6);
        chk("R2 prog cleared on rise", 64'(prog_active), 64'd0);
        chk("R2 pads restored", 64'(pad_oe), 64'(core_oe));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule